// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive, clocked observer placed beside the control lines of an extended-data-out DRAM. It samples the row strobe, one column strobe per byte lane, write enable and output enable on every rising edge of the system clock. For each period in which the row strobe is held low, it works out which kind of memory operation the controller carried out. At the end of that period it reports the result as one code and a mask of the byte lanes that took part.

The classification depends on the order in which the strobes change from one sample to the next. The two column strobes are merged: the merged strobe goes active when the first lane falls and stays active until the last lane rises. Lane activity is still tracked separately for each lane. The block holds no memory data and does not check analog timing. All inputs are taken to be synchronous to the clock.

Top module: `dram_cycle_monitor`

## Requirements
- R1: After reset, and in every cycle without a report, `rep_valid` is 0, `rep_op` is 0 (standby) and `rep_lanes` is 0.
- R2: `rep_valid` is high for exactly one cycle, in the cycle after the first sample that sees `ras_n` high following one or more samples with `ras_n` low. No report is made at any other time.
- R3: If any `cas_n` bit is low in the first sample that sees `ras_n` low, the cycle is reported as refresh-by-column-first (code 7) with lanes 0. This holds even when only one lane is low.
- R4: A row period in which no `cas_n` bit is ever sampled low is reported as row-only refresh (code 6) with lanes 0. The state of the other pins has no effect on this.
- R5: The access type is set in the first sample where any `cas_n` bit is low during the row period. A second lane that falls later, in either lane order, does not set the type again.
- R6: If `we_n` is low in that first column sample, the cycle is an early write (code 3).
- R7: If the cycle started as a read and `we_n` goes from 1 to 0 in a sample where some `cas_n` bit is low, the cycle becomes a delayed write (code 4). A `we_n` fall that happens while both column strobes are high has no effect.
- R8: If that `we_n` fall happens in the same sample as `oe_n` going from 0 to 1, the cycle is read-modify-write (code 5). If `oe_n` stays low during the `we_n` fall, the cycle is a delayed write.
- R9: A cycle with no write is a read (code 1) if `oe_n` was low in some sample where a `cas_n` bit was low. Otherwise it is a read with the output disabled (code 2). An `oe_n` low seen before the column strobe falls does not count.
- R10: For an access cycle, bit i of `rep_lanes` is 1 exactly when `cas_n[i]` was sampled low at some point in the row period. Bit 0 is the lower byte and bit 1 is the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobes, one per byte lane, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rep_valid | output | 1 | One-cycle pulse that marks a report |
| rep_op | output | 4 | Operation code for the cycle just ended |
| rep_lanes | output | LANES | Byte lanes that took part in the cycle |

## Verification
The assertions assume that the pins follow the DRAM protocol. Each row period must begin with `ras_n` low after reset and end with a sample of `ras_n` high, and no other kind of row event may occur. The stimulus drives only such legal sequences. Each sequence starts from an idle sample, keeps the strobes at clean levels for whole clock periods, and always returns `ras_n` high before the next operation. Every operation kind is swept across every nonzero lane mask, and both lane orders are covered when the column strobes are staggered.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [3:0] {
    OP_STANDBY    = 4'd0,
    OP_READ       = 4'd1,
    OP_READ_NOOE  = 4'd2,
    OP_WR_EARLY   = 4'd3,
    OP_WR_DELAYED = 4'd4,
    OP_RMW        = 4'd5,
    OP_RAS_ONLY   = 4'd6,
    OP_CBR        = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACC,
    ST_RFSH
  } st_e;
endpackage

// File: rtl/dcm_edge.sv
// Holds the previous sample of a group of active-low pins (reset to inactive).
module dcm_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= d;
  end
endmodule

// File: rtl/dcm_lane_track.sv
// Sticky per-lane flag: set while tracking is enabled and the lane strobe is low.
module dcm_lane_track #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [LANES-1:0] cas_n,
  output logic [LANES-1:0] seen
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr)          seen[i] <= 1'b0;
      else if (en && !cas_n[i]) seen[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/dcm_classify.sv
module dcm_classify
  import dcm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_any,
  input  logic             we_n,
  input  logic             we_q,
  input  logic             oe_n,
  input  logic             oe_q,
  input  logic [LANES-1:0] lane_seen,
  output logic             track_en,
  output logic             track_clr,
  output logic             rep_valid,
  output op_e              rep_op,
  output logic [LANES-1:0] rep_lanes
);
  st_e  st;
  op_e  cls;
  logic oe_seen;
  logic fire;
  op_e  fin_op;

  assign fire      = ras_n && (st != ST_IDLE);
  assign track_en  = !ras_n && ((st == ST_ROW) || (st == ST_ACC));
  assign track_clr = fire;

  always_comb begin
    case (st)
      ST_ROW:  fin_op = OP_RAS_ONLY;
      ST_RFSH: fin_op = OP_CBR;
      ST_ACC:  fin_op = (cls == OP_READ) ? (oe_seen ? OP_READ : OP_READ_NOOE) : cls;
      default: fin_op = OP_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cls     <= OP_READ;
      oe_seen <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!ras_n) st <= cas_any ? ST_RFSH : ST_ROW;
        end
        ST_ROW: begin
          if (ras_n) begin
            st <= ST_IDLE;
          end else if (cas_any) begin
            st      <= ST_ACC;
            cls     <= we_n ? OP_READ : OP_WR_EARLY;
            oe_seen <= !oe_n;
          end
        end
        ST_ACC: begin
          if (ras_n) begin
            st <= ST_IDLE;
          end else if (cas_any) begin
            if (!oe_n) oe_seen <= 1'b1;
            if (cls == OP_READ && we_q && !we_n)
              cls <= (!oe_q && oe_n) ? OP_RMW : OP_WR_DELAYED;
          end
        end
        default: begin
          if (ras_n) st <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_valid <= 1'b0;
      rep_op    <= OP_STANDBY;
      rep_lanes <= '0;
    end else if (fire) begin
      rep_valid <= 1'b1;
      rep_op    <= fin_op;
      rep_lanes <= lane_seen;
    end else begin
      rep_valid <= 1'b0;
      rep_op    <= OP_STANDBY;
      rep_lanes <= '0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> !rep_valid); // R2
  AST_END_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> ($past(ras_n) && !$past(ras_n, 2))); // R2
  AST_CBR_NO_LANE: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_op == OP_CBR) |-> (rep_lanes == '0)); // R3
  AST_ROWONLY_NO_LANE: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_op == OP_RAS_ONLY) |-> (rep_lanes == '0)); // R4
  AST_ACCESS_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_op != OP_CBR && rep_op != OP_RAS_ONLY) |-> (rep_lanes != '0)); // R10
  AST_NO_STANDBY_REPORT: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> (rep_op != OP_STANDBY)); // R1
endmodule

// File: rtl/dram_cycle_monitor.sv
module dram_cycle_monitor
  import dcm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             rep_valid,
  output logic [3:0]       rep_op,
  output logic [LANES-1:0] rep_lanes
);
  localparam int CTL_W = 2;

  logic [CTL_W-1:0] ctl_q;
  logic             track_en;
  logic             track_clr;
  logic [LANES-1:0] lane_seen;
  op_e              op_int;

  dcm_edge #(.W(CTL_W)) u_edge (
    .clk (clk),
    .rst (rst),
    .d   ({we_n, oe_n}),
    .q   (ctl_q)
  );

  dcm_lane_track #(.LANES(LANES)) u_lanes (
    .clk   (clk),
    .rst   (rst),
    .en    (track_en),
    .clr   (track_clr),
    .cas_n (cas_n),
    .seen  (lane_seen)
  );

  dcm_classify #(.LANES(LANES)) u_cls (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_any   (~&cas_n),
    .we_n      (we_n),
    .we_q      (ctl_q[1]),
    .oe_n      (oe_n),
    .oe_q      (ctl_q[0]),
    .lane_seen (lane_seen),
    .track_en  (track_en),
    .track_clr (track_clr),
    .rep_valid (rep_valid),
    .rep_op    (op_int),
    .rep_lanes (rep_lanes)
  );

  assign rep_op = op_int;
endmodule

// File: tb/dram_cycle_monitor_bench.sv
module dram_cycle_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       ras_n;
  logic [1:0] cas_n;
  logic       we_n;
  logic       oe_n;
  logic       rep_valid;
  logic [3:0] rep_op;
  logic [1:0] rep_lanes;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_monitor #(.LANES(2)) u_dram_cycle_monitor (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .rep_valid(rep_valid), .rep_op(rep_op), .rep_lanes(rep_lanes)
  );

  task automatic step(input logic r, input logic [1:0] c, input logic w, input logic o);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    @(negedge clk);
  endtask

  task automatic check(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // first column-strobe sample(s); staggered falls use the given lane order
  task automatic col_fall(input logic [1:0] lm, input bit stg, input bit upper_first,
                          input logic w, input logic o);
    if (stg) step(1'b0, upper_first ? 2'b01 : 2'b10, w, o);
    step(1'b0, ~lm, w, o);
  endtask

  task automatic run(input int kind, input logic [1:0] lm, input bit stg);
    int exp_op;
    int exp_ln;
    string tag;
    bit uf;
    uf = kind[0];
    exp_ln = lm;
    step(1'b1, 2'b11, 1'b1, 1'b1);
    case (kind)
      0: begin // R3 column strobe(s) low before row falls
        step(1'b1, ~lm, 1'b1, 1'b1);
        step(1'b0, ~lm, 1'b1, 1'b1);
        step(1'b0, ~lm, 1'b0, 1'b1);
        exp_op = 7; exp_ln = 0; tag = "R3";
      end
      1: begin // R4 no column strobe, oe/we toggling ignored
        step(1'b0, 2'b11, 1'b1, 1'b1);
        step(1'b0, 2'b11, 1'b1, 1'b0);
        step(1'b0, 2'b11, 1'b0, 1'b1);
        exp_op = 6; exp_ln = 0; tag = "R4";
      end
      2: begin // R9 read with output enabled
        step(1'b0, 2'b11, 1'b1, 1'b1);
        col_fall(lm, stg, uf, 1'b1, 1'b0);
        step(1'b0, ~lm, 1'b1, 1'b0);
        exp_op = 1; tag = "R9";
      end
      3: begin // R9 oe low only before the column strobe
        step(1'b0, 2'b11, 1'b1, 1'b0);
        col_fall(lm, stg, uf, 1'b1, 1'b1);
        step(1'b0, ~lm, 1'b1, 1'b1);
        exp_op = 2; tag = "R9";
      end
      4: begin // R6 early write
        step(1'b0, 2'b11, 1'b0, 1'b1);
        col_fall(lm, stg, uf, 1'b0, 1'b1);
        step(1'b0, ~lm, 1'b1, 1'b1);
        exp_op = 3; tag = "R6";
      end
      5: begin // R7 delayed write
        step(1'b0, 2'b11, 1'b1, 1'b1);
        col_fall(lm, stg, uf, 1'b1, 1'b1);
        step(1'b0, ~lm, 1'b0, 1'b1);
        exp_op = 4; tag = "R7";
      end
      6: begin // R8 read-modify-write
        step(1'b0, 2'b11, 1'b1, 1'b0);
        col_fall(lm, stg, uf, 1'b1, 1'b0);
        step(1'b0, ~lm, 1'b0, 1'b1);
        exp_op = 5; tag = "R8";
      end
      7: begin // R8 we falls while oe stays low -> delayed write
        step(1'b0, 2'b11, 1'b1, 1'b0);
        col_fall(lm, stg, uf, 1'b1, 1'b0);
        step(1'b0, ~lm, 1'b0, 1'b0);
        exp_op = 4; tag = "R8";
      end
      default: begin // R7 we falls after column strobes went high -> read
        step(1'b0, 2'b11, 1'b1, 1'b1);
        col_fall(lm, stg, uf, 1'b1, 1'b0);
        step(1'b0, 2'b11, 1'b1, 1'b0);
        step(1'b0, 2'b11, 1'b0, 1'b1);
        exp_op = 1; tag = "R7";
      end
    endcase
    if (stg) tag = "R5";
    step(1'b0, 2'b11, 1'b1, 1'b1);
    check(rep_valid, 0, "R2 no report while row low");
    step(1'b1, 2'b11, 1'b1, 1'b1);
    check(rep_valid, 1, "R2 report pulse");
    check(rep_op, exp_op, tag);
    check(rep_lanes, exp_ln, "R10 lanes");
    step(1'b1, 2'b11, 1'b1, 1'b1);
    check(rep_valid, 0, "R2 pulse width");
    check(rep_op, 0, "R1 standby code");
    check(rep_lanes, 0, "R1 standby lanes");
  endtask

  initial begin
    rst = 1'b1;
    step(1'b1, 2'b11, 1'b1, 1'b1);
    step(1'b1, 2'b11, 1'b1, 1'b1);
    rst = 1'b0;
    step(1'b1, 2'b11, 1'b1, 1'b1);
    check(rep_valid, 0, "R1 reset valid");
    check(rep_op, 0, "R1 reset code");
    check(rep_lanes, 0, "R1 reset lanes");
    for (int k = 0; k < 9; k++) begin
      for (int l = 1; l < 4; l++) begin
        run(k, 2'(l), 1'b0);
        if (l == 3 && k > 1) run(k, 2'(l), 1'b1);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule